// File: doc/BRIEF.md
# Crosspoint Route Controller (Parallel Command Port)

This block holds the routing state of an 8-output by 8-input video switch matrix. A host writes a 7-bit word, made of a 3-bit output address and a 4-bit code, through a write strobe. The strobe is gated by two chip selects, one active high and one active low. The controller turns each accepted word into a pending route, an enable change or a transfer command. For every output it drives an input index, a connect-to-ground flag and an enable bit to the analog matrix, which lies outside this block.

Routes are double buffered. A write lands in a per-output pending register, and the matrix sees an active register that is loaded from the pending one. A strap input picks the transfer style. In edge mode, a rising edge of the latch input moves all pending routes at once, so every output reconfigures in the same cycle. In level mode, the active registers follow the pending ones while the latch input is low. Enable commands and the software transfer command bypass this buffering. The raw strobe and latch inputs are asynchronous. Both are brought into the system clock domain through two-flop synchronizers, and their edges are found by comparing successive samples.

Top module: `xbar_route_ctrl`

## Requirements
- R1: A word is accepted only when the raw write strobe rises while `cs_en` is 1 and `cs_en_n` is 0. A strobe pulse with either select inactive changes no route and no enable.
- R2: Codes 0000 to 0111 store that input index as the pending route of the addressed output. They do not change any enable bit.
- R3: Code 1000 stores a ground route for the addressed output. Once active, the output shows `rt_gnd`=1 and `rt_sel`=0.
- R4: Code 1011 disables and code 1100 enables only the addressed output. This takes effect at once in either mode and at either latch level, and it leaves every pending route unchanged. `rt_en` shows only the enable state and does not depend on the route.
- R5: Code 1101 disables all outputs and code 1110 enables all outputs, at once and whatever the latch state. Pending routes are unchanged.
- R6: Code 1111 copies every pending route into its active register when the synchronized latch input is 1. When the latch input is 0, code 1111 has no effect.
- R7: In edge mode (`edge_mode`=1), written routes stay invisible until a rising edge of the latch input. That edge moves all pending routes to the active registers in the same cycle.
- R8: In level mode (`edge_mode`=0), a written route appears on the outputs while the latch input is low. While the latch input is high, the active routes hold, and they catch up once the latch input falls.
- R9: After reset, every output is disabled and selects input 0 with the ground flag clear.
- R10: Codes 1001 and 1010 are ignored and leave every route and enable unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_raw | input | 1 | Asynchronous write strobe; action on its qualified rising edge |
| cs_en | input | 1 | Active-high chip select |
| cs_en_n | input | 1 | Active-low chip select |
| addr | input | 3 | Output address of the word |
| code | input | 4 | Command or input index |
| latch_raw | input | 1 | Asynchronous transfer control |
| edge_mode | input | 1 | Strap: 1 = edge transfer, 0 = level-transparent transfer |
| rt_sel | output | 24 | Input index per output, 3 bits each, output k at bits 3k+2..3k |
| rt_gnd | output | 8 | Per-output connect-to-ground flag |
| rt_en | output | 8 | Per-output enable |

## Verification
The hardest state to reach is a pending route that differs from the active route at the moment a software transfer or a latch edge arrives. It has to be created through the ports without any readback. The bench gets there in edge mode. It writes new routes while the latch input is held still and checks that the outputs keep the old routes. It then issues the transfer command, first with the latch input low, where the command must do nothing, and then with it high, or it raises the latch. Enable commands are placed between the writes and the transfer. This shows that they act at once and do not disturb the pending routes.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] C_GND     = 4'b1000;
  localparam logic [CODE_W-1:0] C_DIS_ONE = 4'b1011;
  localparam logic [CODE_W-1:0] C_EN_ONE  = 4'b1100;
  localparam logic [CODE_W-1:0] C_DIS_ALL = 4'b1101;
  localparam logic [CODE_W-1:0] C_EN_ALL  = 4'b1110;
  localparam logic [CODE_W-1:0] C_SWXFER  = 4'b1111;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ROUTE,
    ACT_DIS_ONE,
    ACT_EN_ONE,
    ACT_DIS_ALL,
    ACT_EN_ALL,
    ACT_XFER
  } xr_act_e;
endpackage

// File: rtl/xr_sync_edge.sv
module xr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign level = sh_q[LAST];
  assign rise  = sh_q[LAST] & ~sh_q[STAGES];
endmodule

// File: rtl/xr_cmd_decode.sv
module xr_cmd_decode
  import xr_pkg::*;
(
  input  logic              fire,
  input  logic [CODE_W-1:0] code,
  input  logic              latch_lvl,
  output xr_act_e           act
);
  always_comb begin
    act = ACT_NONE;
    if (fire) begin
      if (code <= C_GND) act = ACT_ROUTE;
      else begin
        unique case (code)
          C_DIS_ONE: act = ACT_DIS_ONE;
          C_EN_ONE:  act = ACT_EN_ONE;
          C_DIS_ALL: act = ACT_DIS_ALL;
          C_EN_ALL:  act = ACT_EN_ALL;
          C_SWXFER:  act = latch_lvl ? ACT_XFER : ACT_NONE;
          default:   act = ACT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xr_route_store.sv
module xr_route_store
  import xr_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int N_IN  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  xr_act_e                   act,
  input  logic [$clog2(N_OUT)-1:0]  addr,
  input  logic [CODE_W-1:0]         code,
  input  logic                      edge_mode,
  input  logic                      latch_lvl,
  input  logic                      latch_rise,
  output logic [N_OUT*$clog2(N_IN)-1:0] rt_sel,
  output logic [N_OUT-1:0]          rt_gnd,
  output logic [N_OUT-1:0]          rt_en
);
  localparam int AW    = $clog2(N_OUT);
  localparam int IDX_W = $clog2(N_IN);

  logic [N_OUT-1:0][CODE_W-1:0] pend_q, act_q;
  logic [N_OUT-1:0]             en_q;
  logic                         any_write;
  logic                         xfer_sw;

  assign any_write = (act != ACT_NONE);
  assign xfer_sw   = (act == ACT_XFER);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic              hit;
    logic [CODE_W-1:0] pend_nxt;
    logic [CODE_W-1:0] act_nxt;
    logic              en_nxt;

    assign hit      = (addr == AW'(i));
    assign pend_nxt = (act == ACT_ROUTE && hit) ? code : pend_q[i];

    always_comb begin
      act_nxt = act_q[i];
      if (xfer_sw)                    act_nxt = pend_q[i];
      else if (edge_mode) begin
        if (latch_rise)               act_nxt = pend_q[i];
      end else if (!latch_lvl)        act_nxt = pend_nxt;
    end

    always_comb begin
      en_nxt = en_q[i];
      unique case (act)
        ACT_DIS_ALL: en_nxt = 1'b0;
        ACT_EN_ALL:  en_nxt = 1'b1;
        ACT_DIS_ONE: if (hit) en_nxt = 1'b0;
        ACT_EN_ONE:  if (hit) en_nxt = 1'b1;
        default:     en_nxt = en_q[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= '0;
        act_q[i]  <= '0;
        en_q[i]   <= 1'b0;
        rt_sel[i*IDX_W +: IDX_W] <= '0;
        rt_gnd[i] <= 1'b0;
        rt_en[i]  <= 1'b0;
      end else begin
        pend_q[i] <= pend_nxt;
        act_q[i]  <= act_nxt;
        en_q[i]   <= en_nxt;
        rt_gnd[i] <= act_q[i][CODE_W-1];
        rt_sel[i*IDX_W +: IDX_W] <= act_q[i][CODE_W-1] ? '0 : act_q[i][IDX_W-1:0];
        rt_en[i]  <= en_q[i];
      end
    end
  end

  p_en_only_on_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_q) |-> $past(any_write));

  p_pend_only_on_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pend_q) |-> $past(act == ACT_ROUTE));

  p_level_hold_high_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!edge_mode && latch_lvl && !xfer_sw) |-> $stable(act_q));

  p_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $past(edge_mode && !latch_rise && !xfer_sw) |-> $stable(act_q));

  p_xfer_copies_r6: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_sw) |-> (act_q == $past(pend_q)));
endmodule

// File: rtl/xbar_route_ctrl.sv
module xbar_route_ctrl
  import xr_pkg::*;
#(
  parameter int N_OUT       = 8,
  parameter int N_IN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_raw,
  input  logic                              cs_en,
  input  logic                              cs_en_n,
  input  logic [$clog2(N_OUT)-1:0]          addr,
  input  logic [3:0]                        code,
  input  logic                              latch_raw,
  input  logic                              edge_mode,
  output logic [N_OUT*$clog2(N_IN)-1:0]     rt_sel,
  output logic [N_OUT-1:0]                  rt_gnd,
  output logic [N_OUT-1:0]                  rt_en
);
  logic    wr_qual;
  logic    wr_lvl, wr_fire;
  logic    lat_lvl, lat_rise;
  xr_act_e act;

  assign wr_qual = wr_raw & cs_en & ~cs_en_n;

  xr_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .din(wr_qual), .level(wr_lvl), .rise(wr_fire));

  xr_sync_edge #(.STAGES(SYNC_STAGES)) u_lat_sync (
    .clk(clk), .rst(rst), .din(latch_raw), .level(lat_lvl), .rise(lat_rise));

  xr_cmd_decode u_dec (
    .fire(wr_fire), .code(code), .latch_lvl(lat_lvl), .act(act));

  xr_route_store #(.N_OUT(N_OUT), .N_IN(N_IN)) u_store (
    .clk(clk), .rst(rst), .act(act), .addr(addr), .code(code),
    .edge_mode(edge_mode), .latch_lvl(lat_lvl), .latch_rise(lat_rise),
    .rt_sel(rt_sel), .rt_gnd(rt_gnd), .rt_en(rt_en));

  p_fire_single_r1: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !wr_fire);

  p_xfer_needs_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_XFER) |-> lat_lvl);

  p_write_needs_level_r1: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_NONE) |-> wr_lvl);
endmodule

// File: tb/sim_xbar_route_ctrl.sv
module sim_xbar_route_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_raw = 1'b0, cs_en = 1'b1, cs_en_n = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] code = '0;
  logic latch_raw = 1'b0, edge_mode = 1'b0;
  logic [23:0] rt_sel;
  logic [7:0]  rt_gnd, rt_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xbar_route_ctrl u0 (
    .clk(clk), .rst(rst), .wr_raw(wr_raw), .cs_en(cs_en), .cs_en_n(cs_en_n),
    .addr(addr), .code(code), .latch_raw(latch_raw), .edge_mode(edge_mode),
    .rt_sel(rt_sel), .rt_gnd(rt_gnd), .rt_en(rt_en));

  function automatic logic [2:0] sel_of(int k);
    return rt_sel[k*3 +: 3];
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] c);
    @(negedge clk);
    addr = a; code = c; wr_raw = 1'b1;
    repeat (4) @(negedge clk);
    wr_raw = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_latch(logic v);
    @(negedge clk);
    latch_raw = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 en", rt_en, 8'h00);
    chk("R9 sel", rt_sel, 24'h0);
    chk("R9 gnd", rt_gnd, 8'h00);
  endtask

  task automatic t_level_basic;
    edge_mode = 1'b0;
    wr(3'd0, 4'b1110);
    chk("R5 enable all", rt_en, 8'hFF);
    wr(3'd3, 4'd5);
    chk("R8 transparent route", sel_of(3), 3'd5);
    chk("R2 route keeps enables", rt_en, 8'hFF);
    wr(3'd7, 4'd7);
    chk("R2 out7 route", sel_of(7), 3'd7);
  endtask

  task automatic t_qualify;
    cs_en = 1'b0;
    wr(3'd3, 4'd2);
    chk("R1 cs_en low blocks", sel_of(3), 3'd5);
    cs_en = 1'b1; cs_en_n = 1'b1;
    wr(3'd0, 4'b1101);
    chk("R1 cs_en_n high blocks", rt_en, 8'hFF);
    cs_en_n = 1'b0;
  endtask

  task automatic t_ground;
    wr(3'd6, 4'd3);
    wr(3'd6, 4'b1000);
    chk("R3 gnd flag", rt_gnd, 8'h40);
    chk("R3 gnd sel zero", sel_of(6), 3'd0);
  endtask

  task automatic t_single;
    wr(3'd2, 4'b1011);
    chk("R4 disable one", rt_en, 8'hFB);
    chk("R4 route untouched", rt_sel, 24'hE0_0A00 | 24'h0);
    wr(3'd2, 4'b1100);
    chk("R4 enable one", rt_en, 8'hFF);
  endtask

  task automatic t_ignore;
    wr(3'd1, 4'b1001);
    wr(3'd1, 4'b1010);
    chk("R10 en unchanged", rt_en, 8'hFF);
    chk("R10 sel unchanged", rt_sel, 24'hE0_0A00);
    chk("R10 gnd unchanged", rt_gnd, 8'h40);
  endtask

  task automatic t_level_hold;
    set_latch(1'b1);
    wr(3'd0, 4'd7);
    chk("R8 hold while high", sel_of(0), 3'd0);
    set_latch(1'b0);
    chk("R8 catch up on low", sel_of(0), 3'd7);
  endtask

  task automatic t_edge;
    edge_mode = 1'b1;
    wr(3'd1, 4'd3);
    wr(3'd4, 4'd6);
    chk("R7 out1 pending hidden", sel_of(1), 3'd0);
    chk("R7 out4 pending hidden", sel_of(4), 3'd0);
    wr(3'd0, 4'b1101);
    chk("R5 disable all at once", rt_en, 8'h00);
    wr(3'd4, 4'b1100);
    chk("R4 enable one edge mode", rt_en, 8'h10);
    set_latch(1'b1);
    chk("R7 out1 after edge", sel_of(1), 3'd3);
    chk("R7 out4 after edge", sel_of(4), 3'd6);
    chk("R4 en kept by latch", rt_en, 8'h10);
  endtask

  task automatic t_swxfer;
    wr(3'd5, 4'd2);
    chk("R7 no edge no change", sel_of(5), 3'd0);
    wr(3'd0, 4'b1111);
    chk("R6 xfer latch high", sel_of(5), 3'd2);
    set_latch(1'b0);
    wr(3'd5, 4'd4);
    wr(3'd0, 4'b1111);
    chk("R6 xfer latch low nop", sel_of(5), 3'd2);
    set_latch(1'b1);
    chk("R7 edge after nop", sel_of(5), 3'd4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_level_basic();
    t_qualify();
    t_ground();
    t_single();
    t_ignore();
    t_level_hold();
    t_edge();
    t_swxfer();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule